// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into one asynchronous serial frame on a single output line. A producer offers a character on a valid/ready input. The block accepts it only while it is idle. It then sends the frame bit by bit: a start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two stop bits. An external per-bit strobe sets the bit timing. Each bit stays on the line until that strobe moves the block to the next bit, so the baud divider lives outside this block.

The format inputs are sampled when a character is accepted. They are assumed to stay stable while a frame is on the line. The parity bit has four modes: none, even, odd and forced zero. After the last stop bit the block raises a one-cycle completion pulse. The same pulse sets a sticky request flag that stays high until a dedicated clear input drops it.

Back-pressure rules: `s_ready` is high exactly when no frame is in progress. A character is taken on a clock edge where `s_valid` and `s_ready` are both high. While `s_ready` is low, `s_valid` and `s_data` have no effect. A producer that drops `s_valid` during that time loses nothing, because nothing was taken.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0, `s_ready` is 1, `tx_done` is 0 and `req_flag` is 0 until first set.
- R2: When `s_valid` and `s_ready` are both high at a clock edge, the character is accepted. From the next cycle on, `busy` is 1, `s_ready` is 0 and `txd` drives the start bit, which is 0.
- R3: In 8-bit mode (`char7`=0), the 8 data bits follow the start bit with bit 0 first. Each bit of the frame stays unchanged on `txd` until a cycle with `bit_tick`=1 advances it.
- R4: In 7-bit mode (`char7`=1), only data bits 0 to 6 are sent. Bit 7 of `s_data` changes neither the line nor the parity value.
- R5: The parity mode is encoded on `par_mode` as 00 none, 01 even, 10 odd and 11 zero. In even mode the parity bit follows the last data bit and makes the number of 1s in the sent data bits plus the parity bit even.
- R6: In odd mode, the parity bit makes the number of 1s in the sent data bits plus the parity bit odd.
- R7: In zero mode, the parity slot always carries 0. In none mode there is no parity slot, and the stop bits follow the last data bit directly.
- R8: The frame ends with one stop bit (`two_stop`=0) or two stop bits (`two_stop`=1), each a 1.
- R9: In the cycle after the `bit_tick` that ends the last stop bit, `tx_done` is 1 for exactly one cycle. In that same cycle `busy` is 0 and `txd` is 1.
- R10: `s_valid` pulses while a frame is in progress are not accepted. They do not change the frame on the line, and they do not start another frame afterwards.
- R11: `req_flag` becomes 1 in the cycle after `tx_done`, stays 1, and clears in the cycle after `req_clr`=1. When a set and a clear happen in the same cycle, the set wins.
- R12: `bit_tick` pulses while idle have no effect on `txd`, `busy` or `tx_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe that ends the current bit |
| s_valid | input | 1 | Character offered |
| s_ready | output | 1 | Block is idle and will accept a character |
| s_data | input | DATA_W | Character; bit 7 unused in 7-bit mode |
| char7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_mode | input | 2 | 00 none, 01 even, 10 odd, 11 zero |
| two_stop | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| tx_done | output | 1 | One-cycle pulse after the last stop bit |
| req_flag | output | 1 | Sticky completion request |
| req_clr | input | 1 | Clears `req_flag` |

## Verification
The bench builds the block with the default `DATA_W` of 8. With that width, both the 8-bit character path and the 7-bit path that drops the top bit are covered, together with every parity encoding and both stop lengths, up to the longest frame of 12 bits. Each bit period includes one extra cycle without a strobe, so a bit that changes before its strobe is caught. The directed cases send extra writes and strobes in the middle of a frame or while idle, and they make a flag clear coincide with a completion pulse.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_ZERO = 2'b11
  } par_mode_e;
endpackage

// File: rtl/utx_parity.sv
module utx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]   bits,
  input  utx_pkg::par_mode_e  mode,
  output logic                pbit
);
  import utx_pkg::*;
  always_comb begin
    unique case (mode)
      PAR_EVEN: pbit = ^bits;
      PAR_ODD:  pbit = ~(^bits);
      default:  pbit = 1'b0;
    endcase
  end
endmodule

// File: rtl/utx_framer.sv
module utx_framer #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]   data,
  input  logic                char7,
  input  utx_pkg::par_mode_e  mode,
  input  logic                two_stop,
  output logic [FRAME_W-1:0]  frame,
  output logic [CNT_W-1:0]    len
);
  import utx_pkg::*;
  logic [DATA_W-1:0]  masked;
  logic [FRAME_W-1:0] dpad;
  logic [CNT_W-1:0]   nb;
  logic               has_par;
  logic               pbit;

  // the top bit is dropped in short mode so it reaches neither line nor parity
  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      masked[i] = data[i] & ~(char7 && (i == DATA_W - 1));
  end

  utx_parity #(.DATA_W(DATA_W)) u_par (.bits(masked), .mode(mode), .pbit(pbit));

  always_comb begin
    nb      = char7 ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
    has_par = (mode != PAR_NONE);
    dpad    = FRAME_W'(masked);
    frame   = '1;
    frame[0] = 1'b0;
    for (int j = 1; j < FRAME_W; j++) begin
      if (CNT_W'(j) <= nb)
        frame[j] = dpad[j-1];
      else if (has_par && (CNT_W'(j) == nb + CNT_W'(1)))
        frame[j] = pbit;
    end
    len = CNT_W'(1) + nb + CNT_W'(has_par) + (two_stop ? CNT_W'(2) : CNT_W'(1));
  end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   len,
  input  logic               tick,
  output logic               busy,
  output logic               txd,
  output logic               done
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q;
  logic               done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (load) begin
          sh_q   <= frame;
          left_q <= len;
          busy_q <= 1'b1;
        end
      end else if (tick) begin
        if (left_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          sh_q   <= '1;
        end else begin
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q <= left_q - CNT_W'(1);
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign txd  = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/utx_flag.sv
module utx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              char7,
  input  logic [1:0]        par_mode,
  input  logic              two_stop,
  output logic              txd,
  output logic              busy,
  output logic              tx_done,
  output logic              req_flag,
  input  logic              req_clr
);
  import utx_pkg::*;
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;
  logic               accept;

  assign s_ready = ~busy;
  assign accept  = s_valid & s_ready;

  utx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .data(s_data), .char7(char7), .mode(par_mode_e'(par_mode)),
    .two_stop(two_stop), .frame(frame), .len(len)
  );

  utx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .frame(frame), .len(len),
    .tick(bit_tick), .busy(busy), .txd(txd), .done(tx_done)
  );

  utx_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(tx_done), .clr(req_clr), .flag(req_flag)
  );
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic s_valid,
  input logic s_ready,
  input logic txd,
  input logic busy,
  input logic tx_done,
  input logic req_flag,
  input logic req_clr
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> busy);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  assert_hold_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> $stable(txd));
  assert_done_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!busy && $past(busy)));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  assert_idle_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !s_valid) |=> !busy);
  assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> req_flag);
  assert_flag_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr && !tx_done) |=> !req_flag);
endmodule

bind uart_frame_tx utx_checker i_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .s_valid(s_valid),
  .s_ready(s_ready), .txd(txd), .busy(busy), .tx_done(tx_done),
  .req_flag(req_flag), .req_clr(req_clr)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, s_valid = 1'b0, s_ready;
  logic [7:0] s_data = '0;
  logic char7 = 1'b0, two_stop = 1'b0, req_clr = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic txd, busy, tx_done, req_flag;
  int errors = 0, checks = 0, cycles = 0;

  always #4 clk = ~clk;

  uart_frame_tx #(.DATA_W(8)) i_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .char7(char7), .par_mode(par_mode),
    .two_stop(two_stop), .txd(txd), .busy(busy), .tx_done(tx_done),
    .req_flag(req_flag), .req_clr(req_clr)
  );

  // {data[7:0], char7, par_mode[1:0], two_stop}
  localparam logic [11:0] VEC [8] = '{
    {8'hA5, 1'b0, 2'b01, 1'b0}, {8'hA5, 1'b0, 2'b10, 1'b1},
    {8'hFF, 1'b1, 2'b01, 1'b0}, {8'h80, 1'b1, 2'b10, 1'b0},
    {8'h3C, 1'b0, 2'b11, 1'b1}, {8'h5A, 1'b0, 2'b00, 1'b0},
    {8'h01, 1'b1, 2'b00, 1'b1}, {8'hC3, 1'b0, 2'b01, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // expected frame bits, built from the requirement text
  function automatic int build(input logic [7:0] d, input logic c7, input logic [1:0] pm,
                               input logic ts, output logic [15:0] bits);
    int n = 0;
    int nb = c7 ? 7 : 8;
    int ones = 0;
    bits = '1;
    bits[n++] = 1'b0;
    for (int i = 0; i < nb; i++) begin bits[n++] = d[i]; ones += d[i]; end
    if (pm == 2'b01) bits[n++] = (ones % 2 == 1);
    else if (pm == 2'b10) bits[n++] = (ones % 2 == 0);
    else if (pm == 2'b11) bits[n++] = 1'b0;
    bits[n++] = 1'b1;
    if (ts) bits[n++] = 1'b1;
    return n;
  endfunction

  // sends one frame; stray: offer another character mid-frame (R10)
  task automatic send(input logic [7:0] d, input logic c7, input logic [1:0] pm,
                      input logic ts, input bit stray, input string tag);
    logic [15:0] exp_bits, got_bits;
    int exp_len, got_len;
    bit stable_ok = 1'b1;
    exp_len = build(d, c7, pm, ts, exp_bits);
    got_bits = '1; got_len = 0;
    @(negedge clk);
    s_data = d; char7 = c7; par_mode = pm; two_stop = ts; s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check({tag, " R2 busy"}, {busy, s_ready}, 2'b10);
    for (int k = 0; k < 16; k++) begin
      got_bits[k] = txd;
      if (stray && k == 3) begin s_valid = 1'b1; s_data = ~d; end
      @(negedge clk);
      s_valid = 1'b0;
      if (txd !== got_bits[k]) stable_ok = 1'b0;
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      if (tx_done) begin got_len = k + 1; break; end
    end
    check({tag, " R3 bits held until tick"}, stable_ok, 1);
    check({tag, " R5 R6 R7 R8 frame length"}, got_len, exp_len);
    check({tag, " R3 R4 frame bits"}, got_bits, exp_bits);
    check({tag, " R9 done/busy/txd"}, {tx_done, busy, txd}, 3'b101);
    @(negedge clk);
    check({tag, " R9 single pulse"}, tx_done, 0);
    check({tag, " R11 flag set"}, req_flag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {txd, busy, s_ready, tx_done, req_flag}, 5'b10100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {txd, busy, s_ready}, 3'b101);

    for (int v = 0; v < 8; v++)
      send(VEC[v][11:4], VEC[v][3], VEC[v][2:1], VEC[v][0], 1'b0, $sformatf("vec%0d", v));

    // R11: clear input drops the flag
    @(negedge clk); req_clr = 1'b1;
    @(negedge clk); req_clr = 1'b0;
    check("R11 flag cleared", req_flag, 0);

    // R12: strobes while idle
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
    check("R12 idle ticks no effect", {txd, busy, tx_done}, 3'b100);

    // R4: top bit alone in short mode gives the same frame as zero
    send(8'h80, 1'b1, 2'b01, 1'b0, 1'b0, "R4 top bit ignored");

    // R10: write during frame ignored, no frame afterwards
    send(8'h96, 1'b0, 2'b10, 1'b0, 1'b1, "R10 mid-frame write");
    repeat (4) @(negedge clk);
    check("R10 no second frame", {busy, txd}, 2'b01);

    // R11: set and clear in the same cycle, set wins
    @(negedge clk);
    s_data = 8'h00; char7 = 1'b1; par_mode = 2'b00; two_stop = 1'b0; s_valid = 1'b1;
    @(negedge clk); s_valid = 1'b0;
    req_clr = 1'b1;
    for (int k = 0; k < 16; k++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      if (tx_done) break;
    end
    check("R11 pulse seen", tx_done, 1);
    @(negedge clk);
    req_clr = 1'b0;
    check("R11 set wins over clear", req_flag, 1);
    check("R1 idle between frames", {txd, busy, s_ready, tx_done}, 4'b1010);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule